// File: doc/BRIEF.md
# Bipolar violation monitor

This block watches a dual-rail line receiver. On each receive clock it takes one symbol, given as a positive-mark rail and a negative-mark rail. It raises a one-cycle strobe for every code violation that the chosen line code does not allow. A bipolar violation is a mark that has the same polarity as the mark before it, however many zeros lie between the two. In plain alternate-mark-inversion use, every such event is reported.

When the line carries HDB3 or B8ZS zero substitution, the deliberate violations that those codes insert are recognised and suppressed. The strobe then reports only genuine in-service code errors. A cycle with both rails high is not a legal symbol and is flagged as well.

The block keeps a short history of classified symbols, so the pattern context is known on both sides of each violation. Every decision is made at a fixed history stage. As a result, the strobe lags the symbol that caused it by a constant number of clocks. The line code is picked with a two-bit select. It is meant to be held steady while traffic flows.

Top module: `bpv_monitor`

## Requirements
- R1: A symbol is decoded from the rails as pos=1,neg=0 for a positive mark, pos=0,neg=1 for a negative mark, and both low for a zero. A mark whose polarity alternates from the previous mark is never flagged.
- R2: With code_sel 2'b00 or 2'b11 (plain alternate mark inversion), every mark with the same polarity as the previous mark is flagged, whatever the zeros in between and whatever pattern precedes it.
- R3: A symbol with both rails high is flagged. It does not change the remembered polarity of the last mark, and it counts as neither a mark nor a zero in any substitution pattern.
- R4: Reset clears the output, the history and the remembered polarity. The first mark after reset is never flagged, and no strobe pending at reset appears after it.
- R5: With code_sel 2'b01 (HDB3), a violation is suppressed when both of these hold. First, the three symbols before it are zeros, or they are a non-violating mark followed by two zeros. Second, its polarity is opposite to that of the previous violation seen in this mode, or no earlier violation exists. Every violation in this mode, reported or not, becomes the new reference polarity.
- R6: With code_sel 2'b01, a violation that fails either check of R5 is flagged.
- R7: With code_sel 2'b10 (B8ZS), the eight-symbol run zero, zero, zero, V, B, zero, V, B is recognised. Here V is a violating mark and B is a non-violating mark. Both violations in the run are suppressed.
- R8: With code_sel 2'b10, a violation that is not the fourth or seventh symbol of a complete R7 run is flagged, including a lone zero-zero-zero-violation group.
- R9: A flagged symbol sampled on rising edge k drives bpv_o high after rising edge k+5, for exactly one clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_i | input | 1 | Positive-mark rail for the current bit |
| neg_i | input | 1 | Negative-mark rail for the current bit |
| code_sel | input | 2 | Line code: 00 AMI, 01 HDB3, 10 B8ZS, 11 AMI |
| bpv_o | output | 1 | One-cycle code violation strobe |

## Verification
In B8ZS mode, the final B of a valid run arrives on the same edge that moves the run's first violation into the report stage. The retroactive suppression and the pipeline shift therefore land together. The vector table builds such a run after a mark. The check five edges later demands a low output for the first violation, so a write-back that misses the shifting entry is caught. The run that follows breaks off one symbol short and must flag both of its violations. That contrast judges that the same stage reports when no write-back arrives.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

   typedef enum logic [1:0] {
      LC_AMI     = 2'b00,
      LC_HDB3    = 2'b01,
      LC_B8ZS    = 2'b10,
      LC_AMI_ALT = 2'b11
   } line_code_e;

   // one classified symbol as kept in the history
   typedef struct packed {
      logic mark;   // exactly one rail high
      logic viol;   // same polarity as the previous mark
      logic inval;  // both rails high
      logic supp;   // violation belongs to a legal substitution
   } sym_t;

   // span of the longest substitution pattern, in symbols
   localparam int B8ZS_SPAN        = 8;
   // earliest stage at which every suppression has been decided
   localparam int MIN_REPORT_STAGE = 4;
   // stages that receive the B8ZS write-back on the completing edge
   localparam int B8ZS_LATE_V      = 1;
   localparam int B8ZS_EARLY_V     = 4;

   function automatic logic sym_is_zero(input sym_t s);
      return !s.mark && !s.inval;
   endfunction

   function automatic logic sym_is_clean_mark(input sym_t s);
      return s.mark && !s.viol;
   endfunction

   function automatic logic sym_is_v(input sym_t s);
      return s.mark && s.viol;
   endfunction

endpackage

// File: rtl/bpv_symbol_class.sv
module bpv_symbol_class
   import bpv_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic pos_i,
   input  logic neg_i,
   output sym_t sym_o,
   output logic pol_o
);

   logic have_mark_q;
   logic last_pol_q;
   logic mark_w;
   logic inval_w;
   logic viol_w;

   always_comb begin
      mark_w  = pos_i ^ neg_i;
      inval_w = pos_i & neg_i;
      viol_w  = mark_w & have_mark_q & (pos_i == last_pol_q);
      sym_o   = '{mark: mark_w, viol: viol_w, inval: inval_w, supp: 1'b0};
      pol_o   = pos_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         have_mark_q <= 1'b0;
         last_pol_q  <= 1'b0;
      end else if (mark_w) begin
         have_mark_q <= 1'b1;
         last_pol_q  <= pos_i;
      end
   end

   // R3: an illegal both-rails symbol leaves the polarity memory untouched
   p_inval_holds_pol_r3: assert property (@(posedge clk) disable iff (rst)
      (pos_i && neg_i) |=> ($stable(last_pol_q) && $stable(have_mark_q)))
      else $error("illegal symbol changed the last-mark polarity");

endmodule

// File: rtl/bpv_subst_detect.sv
module bpv_subst_detect
   import bpv_pkg::*;
#(
   parameter int DEPTH   = 7,
   parameter bit EN_HDB3 = 1'b1,
   parameter bit EN_B8ZS = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] code_sel,
   input  sym_t       in_sym,
   input  logic       in_pol,
   input  sym_t       win [DEPTH],
   output logic       hdb3_hit,
   output logic       b8_hit
);

   generate
      if (EN_HDB3) begin : g_hdb3
         logic lastv_valid_q;
         logic lastv_pol_q;
         logic hdb3_mode;
         logic ctx_ok;
         logic alt_ok;

         always_comb begin
            hdb3_mode = (code_sel == LC_HDB3);
            ctx_ok    = sym_is_zero(win[0]) && sym_is_zero(win[1]) &&
                        (sym_is_zero(win[2]) || sym_is_clean_mark(win[2]));
            alt_ok    = !lastv_valid_q || (in_pol != lastv_pol_q);
         end

         assign hdb3_hit = hdb3_mode && in_sym.viol && ctx_ok && alt_ok;

         always_ff @(posedge clk) begin
            if (rst) begin
               lastv_valid_q <= 1'b0;
               lastv_pol_q   <= 1'b0;
            end else if (hdb3_mode && in_sym.viol) begin
               lastv_valid_q <= 1'b1;
               lastv_pol_q   <= in_pol;
            end
         end

         // R5: each violation seen in HDB3 mode becomes the new reference
         p_v_pol_tracked_r5: assert property (@(posedge clk) disable iff (rst)
            (code_sel == LC_HDB3 && in_sym.viol) |=>
               (lastv_valid_q && lastv_pol_q == $past(in_pol)))
            else $error("HDB3 reference polarity not updated");
      end else begin : g_no_hdb3
         assign hdb3_hit = 1'b0;
      end

      if (EN_B8ZS) begin : g_b8zs
         // incoming symbol closes 0 0 0 V B 0 V B; win[0] is the newest entry
         assign b8_hit = (code_sel == LC_B8ZS) &&
                         sym_is_clean_mark(in_sym) &&
                         sym_is_v(win[0])          &&
                         sym_is_zero(win[1])       &&
                         sym_is_clean_mark(win[2]) &&
                         sym_is_v(win[3])          &&
                         sym_is_zero(win[4])       &&
                         sym_is_zero(win[5])       &&
                         sym_is_zero(win[6]);
      end else begin : g_no_b8zs
         assign b8_hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bpv_history.sv
module bpv_history
   import bpv_pkg::*;
#(
   parameter int DEPTH = 7,
   parameter int RPT   = 4
) (
   input  logic clk,
   input  logic rst,
   input  sym_t in_sym,
   input  logic hdb3_hit,
   input  logic b8_hit,
   output sym_t win [DEPTH],
   output sym_t rpt_sym
);

   sym_t sr_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) sr_q[k] <= '0;
      end else begin
         sr_q[0] <= '{mark:  in_sym.mark,
                      viol:  in_sym.viol,
                      inval: in_sym.inval,
                      supp:  in_sym.supp | hdb3_hit};
         for (int k = 1; k < DEPTH; k++) begin
            sr_q[k] <= sr_q[k-1];
            if (b8_hit && (k == B8ZS_LATE_V || k == B8ZS_EARLY_V))
               sr_q[k].supp <= 1'b1;
         end
      end
   end

   assign win     = sr_q;
   assign rpt_sym = sr_q[RPT];

   // R7: a suppression mark only ever lands on a violating entry
   p_supp_marks_viol_r7: assert property (@(posedge clk) disable iff (rst)
      sr_q[RPT].supp |-> sr_q[RPT].viol)
      else $error("suppression recorded on a non-violating symbol");

endmodule

// File: rtl/bpv_strobe.sv
module bpv_strobe
   import bpv_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  sym_t rpt_sym,
   output logic strobe_o
);

   logic strobe_q;

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= 1'b0;
      else     strobe_q <= (rpt_sym.viol && !rpt_sym.supp) || rpt_sym.inval;
   end

   assign strobe_o = strobe_q;

   // R4: the first cycle after reset never carries a strobe
   p_quiet_after_reset_r4: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !strobe_q)
      else $error("strobe survived reset");

endmodule

// File: rtl/bpv_monitor.sv
module bpv_monitor
   import bpv_pkg::*;
#(
   parameter int SYM_WIN   = 8,
   parameter int RPT_STAGE = 4,
   parameter bit EN_HDB3   = 1'b1,
   parameter bit EN_B8ZS   = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pos_i,
   input  logic       neg_i,
   input  logic [1:0] code_sel,
   output logic       bpv_o
);

   localparam int STORED = SYM_WIN - 1;
   localparam int DEPTH  = (STORED > RPT_STAGE + 1) ? STORED : RPT_STAGE + 1;

   generate
      if (SYM_WIN < B8ZS_SPAN) begin : g_bad_win
         $error("SYM_WIN must cover the longest substitution pattern");
      end
      if (RPT_STAGE < MIN_REPORT_STAGE) begin : g_bad_rpt
         $error("RPT_STAGE too early for B8ZS write-back");
      end
   endgenerate

   sym_t cls_sym;
   logic cls_pol;
   sym_t hist_win [DEPTH];
   sym_t rpt_sym;
   logic hdb3_hit;
   logic b8_hit;

   bpv_symbol_class u_class (
      .clk   (clk),
      .rst   (rst),
      .pos_i (pos_i),
      .neg_i (neg_i),
      .sym_o (cls_sym),
      .pol_o (cls_pol)
   );

   bpv_subst_detect #(
      .DEPTH   (DEPTH),
      .EN_HDB3 (EN_HDB3),
      .EN_B8ZS (EN_B8ZS)
   ) u_detect (
      .clk      (clk),
      .rst      (rst),
      .code_sel (code_sel),
      .in_sym   (cls_sym),
      .in_pol   (cls_pol),
      .win      (hist_win),
      .hdb3_hit (hdb3_hit),
      .b8_hit   (b8_hit)
   );

   bpv_history #(
      .DEPTH (DEPTH),
      .RPT   (RPT_STAGE)
   ) u_hist (
      .clk      (clk),
      .rst      (rst),
      .in_sym   (cls_sym),
      .hdb3_hit (hdb3_hit),
      .b8_hit   (b8_hit),
      .win      (hist_win),
      .rpt_sym  (rpt_sym)
   );

   bpv_strobe u_strobe (
      .clk      (clk),
      .rst      (rst),
      .rpt_sym  (rpt_sym),
      .strobe_o (bpv_o)
   );

endmodule

// File: tb/bpv_monitor_test.sv
`timescale 1ns/1ps
module bpv_monitor_test;

   localparam int NVEC = 62;
   localparam int LAT  = 6;  // negedges from drive to observable strobe

   // {code_sel[1:0], pos, neg, expected flag}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b00_10_0, 5'b00_01_0, 5'b00_10_0, 5'b00_10_1,   // 0-3   AMI
      5'b00_00_0, 5'b00_00_0, 5'b00_10_1, 5'b00_01_0,   // 4-7
      5'b00_11_1, 5'b00_01_1, 5'b00_10_0, 5'b00_00_0,   // 8-11
      5'b00_00_0, 5'b00_00_0, 5'b00_10_1, 5'b00_01_0,   // 12-15
      5'b01_00_0, 5'b01_00_0, 5'b01_00_0, 5'b01_01_0,   // 16-19  HDB3 000V
      5'b01_10_0, 5'b01_00_0, 5'b01_00_0, 5'b01_10_0,   // 20-23  B00V
      5'b01_01_0, 5'b01_00_0, 5'b01_00_0, 5'b01_00_0,   // 24-27
      5'b01_01_0, 5'b01_00_0, 5'b01_00_0, 5'b01_00_0,   // 28-31
      5'b01_01_1, 5'b01_10_0, 5'b01_10_1, 5'b01_00_0,   // 32-35  same-pol V, bare V
      5'b01_11_1, 5'b01_00_0, 5'b01_10_1, 5'b01_01_0,   // 36-39  broken context
      5'b01_00_0, 5'b01_00_0, 5'b01_01_0, 5'b10_10_0,   // 40-43  B00V, then B8ZS
      5'b10_00_0, 5'b10_00_0, 5'b10_00_0, 5'b10_10_0,   // 44-47
      5'b10_01_0, 5'b10_00_0, 5'b10_01_0, 5'b10_10_0,   // 48-51  full run
      5'b10_01_0, 5'b10_00_0, 5'b10_00_0, 5'b10_00_0,   // 52-55
      5'b10_01_1, 5'b10_10_0, 5'b10_00_0, 5'b10_10_1,   // 56-59  truncated run
      5'b10_00_0, 5'b10_01_0                            // 60-61
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pos_d = 1'b0;
   logic       neg_d = 1'b0;
   logic [1:0] sel_d = 2'b00;
   logic       bpv_o;
   int         nchk = 0;
   int         nerr = 0;

   always #10 clk = ~clk;

   bpv_monitor uut (
      .clk      (clk),
      .rst      (rst),
      .pos_i    (pos_d),
      .neg_i    (neg_d),
      .code_sel (sel_d),
      .bpv_o    (bpv_o)
   );

   function automatic string vec_tag(input logic [4:0] v);
      if (v[2] && v[1]) return "R3";
      case (v[4:3])
         2'b01:   return v[0] ? "R6" : "R5";
         2'b10:   return v[0] ? "R8" : "R7";
         default: return v[0] ? "R2" : "R1";
      endcase
   endfunction

   task automatic check(input logic exp, input string tag);
      nchk++;
      if (bpv_o !== exp) begin
         nerr++;
         $display("FAIL %s: bpv_o=%0b expected %0b at %0t", tag, bpv_o, exp, $time);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic p, input logic n);
      @(negedge clk);
      sel_d = m;
      pos_d = p;
      neg_d = n;
   endtask

   task automatic idle_check(input logic exp, input string tag);
      @(negedge clk);
      check(exp, tag);
      pos_d = 1'b0;
      neg_d = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1'b0, "R4 reset state");
      rst = 1'b0;

      // vector table, each flag observed LAT negedges after it was driven (R9)
      for (int i = 0; i < NVEC + LAT; i++) begin
         @(negedge clk);
         if (i >= LAT)
            check(VEC[i-LAT][0], $sformatf("%s/R9 vector %0d", vec_tag(VEC[i-LAT]), i - LAT));
         if (i < NVEC) begin
            sel_d = VEC[i][4:3];
            pos_d = VEC[i][2];
            neg_d = VEC[i][1];
         end else begin
            sel_d = 2'b00;
            pos_d = 1'b0;
            neg_d = 1'b0;
         end
      end

      // R4: a violation in flight is dropped by reset
      drive(2'b00, 1'b1, 1'b0);
      drive(2'b00, 1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1; pos_d = 1'b0; neg_d = 1'b0;
      @(negedge clk);
      check(1'b0, "R4 output low in reset");
      rst = 1'b0;
      for (int i = 0; i < 6; i++) idle_check(1'b0, "R4 pending strobe cleared");

      // R2 with code 11, R4 first mark, R9 single-cycle width
      drive(2'b11, 1'b1, 1'b0);
      drive(2'b11, 1'b0, 1'b0);
      drive(2'b11, 1'b0, 1'b0);
      drive(2'b11, 1'b0, 1'b0);
      drive(2'b11, 1'b1, 1'b0);
      drive(2'b11, 1'b0, 1'b0);
      idle_check(1'b0, "R4 first mark after reset");
      idle_check(1'b0, "R2 zero");
      idle_check(1'b0, "R2 zero");
      idle_check(1'b0, "R2 zero");
      idle_check(1'b1, "R2 code 11 reports 000V");
      idle_check(1'b0, "R9 strobe one cycle wide");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule